// File: doc/BRIEF.md
# Bit-Select PWM Generator

This block produces a single pulse-width-modulated output from an 8-bit counter. The counter advances once per strobe on a tick input, which the surrounding chip pulses at 32 kHz. The period is not set by a compare register. Instead, a 2-bit divider field picks which counter bit clears the counter. This gives periods of 128, 64, 32 or 16 ticks, which at a 32 kHz tick are 250 Hz, 500 Hz, 1 kHz and 2 kHz. A 7-bit duty value sets how many ticks of each period the output stays high.

A host programs the block through a small synchronous register port, with a control word at offset 0 and a duty word at offset 1. When the run bit is clear, the output pin carries a plain general-purpose output level in place of the waveform. Several behaviours are kept on purpose:

- Changing the divider does not restart the counter.
- A new duty value acts at once, not at the next period boundary.
- A constant-high output cannot be produced at the slowest divider setting.

Top module: `bitsel_pwm`

## Requirements
- R1: After reset the control word and the duty word both read 0x00, the counter is zero and `pwm_pin` is low.
- R2: The control word sits at address 0, with the run flag in bit 7 and the divider in bits 1:0. Bits 6:2 read as zero. The duty word sits at address 1 and keeps bits 6:0, with bit 7 reading as zero. Any other address reads 0x00. `rdata` is loaded on the clock edge where `rd_en` is high and holds its value otherwise.
- R3: The counter steps only on a clock edge where `tick` is high and the run flag is set. While the run flag is clear the counter is forced to zero, so a fresh enable starts a new period from count 0.
- R4: With divider value d, the counter clears on the tick where its incremented value would have bit 7−d set. The period is therefore 2^(7−d) ticks.
- R5: On each clock edge the pin is loaded with 1 when (count AND (2^(7−d)−1)) is less than the duty word, and with 0 otherwise. The pin reflects the counter one clock after the counter changes.
- R6: For d ≥ 1, a duty word equal to 2^(7−d) keeps the pin constant high. For d = 0 the largest storable duty is 127, so the pin is low for one tick in every 128.
- R7: Writing a new divider leaves the counter untouched. If the count is already past the new range, the counter keeps stepping until its incremented value has the newly selected bit set.
- R8: A new duty word is used in the very next compare, part-way through a period, with no shadow copy.
- R9: While the run flag is clear, `pwm_pin` is loaded with `gpio_out` on every clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick | input | 1 | Single-cycle counter advance strobe (nominally 32 kHz) |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 8 | Registered read data |
| gpio_out | input | 1 | Level driven onto the pin while the generator is stopped |
| pwm_pin | output | 1 | Registered pin output |

## Verification
The bench uses the default parameters: an 8-bit counter with a 2-bit divider. All four clear-bit choices are therefore reachable, and so is the 127-of-128 ceiling at the slowest setting. At this width the divider glitch can be provoked by moving from divider 0 to divider 3 with the count at 100. The counter then runs up to 111 before clearing. A duty change at count 3 of a 16-tick period shows the new value taking effect mid-period. The general-purpose output is toggled before the first enable and again after the block is stopped.

// File: rtl/bitsel_pwm_pkg.sv
package bitsel_pwm_pkg;

  localparam int unsigned CTRL_OFS = 0;
  localparam int unsigned DUTY_OFS = 1;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_CTRL = 2'd1,
    SEL_DUTY = 2'd2
  } reg_sel_e;

endpackage

// File: rtl/bitsel_pwm_regs.sv
module bitsel_pwm_regs
  import bitsel_pwm_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8,
  parameter int PSC_W  = 2,
  parameter int DUTY_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rdata,
  output logic              run,
  output logic [PSC_W-1:0]  psc,
  output logic [DUTY_W-1:0] duty
);

  reg_sel_e          sel;
  logic              run_q, run_d;
  logic [PSC_W-1:0]  psc_q, psc_d;
  logic [DUTY_W-1:0] duty_q, duty_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic [DATA_W-1:0] ctrl_view;

  // address decode
  always_comb begin
    sel = SEL_NONE;
    if (addr == ADDR_W'(CTRL_OFS))      sel = SEL_CTRL;
    else if (addr == ADDR_W'(DUTY_OFS)) sel = SEL_DUTY;
  end

  // control word as seen by the host: run flag on top, divider at the bottom
  always_comb begin
    ctrl_view              = '0;
    ctrl_view[DATA_W-1]    = run_q;
    ctrl_view[PSC_W-1:0]   = psc_q;
  end

  // next state
  always_comb begin
    run_d   = run_q;
    psc_d   = psc_q;
    duty_d  = duty_q;
    rdata_d = rdata_q;
    if (wr_en && (sel == SEL_CTRL)) begin
      run_d = wdata[DATA_W-1];
      psc_d = wdata[PSC_W-1:0];
    end
    if (wr_en && (sel == SEL_DUTY)) begin
      duty_d = wdata[DUTY_W-1:0];
    end
    if (rd_en) begin
      case (sel)
        SEL_CTRL: rdata_d = ctrl_view;
        SEL_DUTY: rdata_d = DATA_W'(duty_q);
        default:  rdata_d = '0;
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      psc_q   <= '0;
      duty_q  <= '0;
      rdata_q <= '0;
    end else begin
      run_q   <= run_d;
      psc_q   <= psc_d;
      duty_q  <= duty_d;
      rdata_q <= rdata_d;
    end
  end

  assign rdata = rdata_q;
  assign run   = run_q;
  assign psc   = psc_q;
  assign duty  = duty_q;

  // R2
  ctrl_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (sel == SEL_CTRL)) |=> (rdata[DATA_W-2:PSC_W] == '0));

  // R2
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));

endmodule

// File: rtl/bitsel_pwm_counter.sv
module bitsel_pwm_counter #(
  parameter int CNT_W = 8,
  parameter int PSC_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic [PSC_W-1:0] psc,
  output logic [CNT_W-1:0] cnt
);

  localparam int NSEL = 1 << PSC_W;

  logic [CNT_W-1:0] cnt_q, cnt_d, inc;
  logic [NSEL-1:0]  hit;
  logic             clr;

  assign inc = cnt_q + CNT_W'(1);

  // one clear-bit candidate per divider value
  for (genvar g = 0; g < NSEL; g++) begin : g_sel
    assign hit[g] = (psc == PSC_W'(g)) && inc[CNT_W-1-g];
  end

  assign clr = |hit;

  always_comb begin
    if (!run)      cnt_d = '0;
    else if (tick) cnt_d = clr ? '0 : inc;
    else           cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  // R3
  cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> $stable(cnt_q));

  // R3
  cnt_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0));

  // R4
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick) |=> ((cnt_q == '0) || (cnt_q == CNT_W'($past(cnt_q) + 1'b1))));

endmodule

// File: rtl/bitsel_pwm_out.sv
module bitsel_pwm_out #(
  parameter int CNT_W  = 8,
  parameter int PSC_W  = 2,
  parameter int DUTY_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [PSC_W-1:0]  psc,
  input  logic [DUTY_W-1:0] duty,
  input  logic              run,
  input  logic              gpio,
  output logic              pin
);

  logic [CNT_W-1:0] mask;
  logic             active;
  logic             pin_q, pin_d;

  always_comb begin
    mask   = (CNT_W'(1) << (CNT_W'(CNT_W - 1) - CNT_W'(psc))) - CNT_W'(1);
    active = (cnt & mask) < CNT_W'(duty);
    pin_d  = run ? active : gpio;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= 1'b0;
    else        pin_q <= pin_d;
  end

  assign pin = pin_q;

  // R9
  gpio_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (pin_q == $past(gpio)));

  // R5
  duty_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && (duty == '0)) |=> !pin_q);

endmodule

// File: rtl/bitsel_pwm.sv
module bitsel_pwm #(
  parameter int CNT_W  = 8,
  parameter int PSC_W  = 2,
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rdata,
  input  logic              gpio_out,
  output logic              pwm_pin
);

  localparam int DUTY_W = CNT_W - 1;

  logic [1:0]        rst_sync_q;
  logic              rst_sync_n;
  logic              run;
  logic [PSC_W-1:0]  psc;
  logic [DUTY_W-1:0] duty;
  logic [CNT_W-1:0]  cnt;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  bitsel_pwm_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PSC_W(PSC_W), .DUTY_W(DUTY_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .addr(addr), .wdata(wdata),
    .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata),
    .run(run), .psc(psc), .duty(duty)
  );

  bitsel_pwm_counter #(
    .CNT_W(CNT_W), .PSC_W(PSC_W)
  ) u_cnt (
    .clk(clk), .rst_n(rst_sync_n), .tick(tick), .run(run), .psc(psc), .cnt(cnt)
  );

  bitsel_pwm_out #(
    .CNT_W(CNT_W), .PSC_W(PSC_W), .DUTY_W(DUTY_W)
  ) u_out (
    .clk(clk), .rst_n(rst_sync_n), .cnt(cnt), .psc(psc), .duty(duty),
    .run(run), .gpio(gpio_out), .pin(pwm_pin)
  );

  // R6
  slow_full_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (run && (psc == '0) && (cnt[CNT_W-2:0] == '1)) |=> !pwm_pin);

endmodule

// File: tb/bitsel_pwm_tb_top.sv
module bitsel_pwm_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic       clk;
  logic       rst_n;
  logic       tick;
  logic [1:0] addr;
  logic [7:0] wdata;
  logic       wr_en;
  logic       rd_en;
  logic [7:0] rdata;
  logic       gpio_out;
  logic       pwm_pin;

  bitsel_pwm dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .addr(addr), .wdata(wdata),
    .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata),
    .gpio_out(gpio_out), .pwm_pin(pwm_pin)
  );

  typedef struct {
    logic  v;
    string tag;
  } item_t;

  item_t q[$];
  int    checks = 0;
  int    fails  = 0;
  string phase  = "R1";

  // staged stimulus for the next cycle
  logic       s_tick = 1'b1;
  logic       s_wr = 1'b0, s_rd = 1'b0, s_gpio = 1'b0;
  logic [1:0] s_addr = 2'd0;
  logic [7:0] s_wdata = 8'd0;

  // requirement-level model
  logic       m_en = 1'b0;
  logic [1:0] m_psc = 2'd0;
  logic [6:0] m_duty = 7'd0;
  logic [7:0] m_cnt = 8'd0;

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  // driver: one clock cycle, pushes the expected pin value for the coming edge
  task automatic run_cycle();
    item_t      it;
    logic [7:0] msk;
    logic [7:0] nx;
    @(negedge clk);
    tick = s_tick; wr_en = s_wr; rd_en = s_rd; addr = s_addr;
    wdata = s_wdata; gpio_out = s_gpio;
    msk = (8'd1 << (3'd7 - {1'b0, m_psc})) - 8'd1;
    it.v   = m_en ? ((m_cnt & msk) < {1'b0, m_duty}) : s_gpio;
    it.tag = phase;
    q.push_back(it);
    @(posedge clk);
    if (!m_en) m_cnt = 8'd0;
    else if (s_tick) begin
      nx = m_cnt + 8'd1;
      m_cnt = nx[3'd7 - {1'b0, m_psc}] ? 8'd0 : nx;
    end
    if (s_wr && s_addr == 2'd0) begin m_en = s_wdata[7]; m_psc = s_wdata[1:0]; end
    if (s_wr && s_addr == 2'd1) m_duty = s_wdata[6:0];
    s_wr = 1'b0; s_rd = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    s_wr = 1'b1; s_addr = a; s_wdata = d;
    run_cycle();
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [7:0] exp, input string tag);
    s_rd = 1'b1; s_addr = a;
    run_cycle();
    #2;
    checks++;
    if (rdata !== exp) begin
      fails++;
      $display("FAIL %s: rdata=%02h expected %02h", tag, rdata, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) run_cycle();
  endtask

  // monitor: compares the pin one step after each edge
  initial begin
    item_t it;
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        it = q.pop_front();
        checks++;
        if (pwm_pin !== it.v) begin
          fails++;
          $display("FAIL %s: pwm_pin=%0b expected %0b", it.tag, pwm_pin, it.v);
        end
      end
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tick = 1'b0; addr = 2'd0; wdata = 8'd0;
    wr_en = 1'b0; rd_en = 1'b0; gpio_out = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: pin low out of reset
    checks++;
    if (pwm_pin !== 1'b0) begin
      fails++;
      $display("FAIL R1: pwm_pin=%0b expected 0", pwm_pin);
    end
    idle(3);
    rd_chk(2'd0, 8'h00, "R1");
    rd_chk(2'd1, 8'h00, "R1");
    rd_chk(2'd2, 8'h00, "R2");

    // R9: stopped, pin follows gpio_out
    phase = "R9";
    for (int i = 0; i < 8; i++) begin
      s_gpio = i[1];
      run_cycle();
    end
    s_gpio = 1'b0;

    // R2: field layout and dropped bits
    phase = "R2";
    wr(2'd1, 8'h85);
    rd_chk(2'd1, 8'h05, "R2");
    wr(2'd0, 8'hFE);
    rd_chk(2'd0, 8'h82, "R2");
    rd_chk(2'd3, 8'h00, "R2");

    // R4 / R5: divider 2, duty 5, 32-tick period
    phase = "R5";
    idle(70);
    phase = "R4";
    wr(2'd0, 8'h83);
    idle(40);

    // R3: sparse ticks
    phase = "R3";
    for (int i = 0; i < 45; i++) begin
      s_tick = (i % 3 == 0);
      run_cycle();
    end
    s_tick = 1'b1;

    // R6: divider 1 with duty 64 is always high
    phase = "R6";
    wr(2'd1, 8'd64);
    wr(2'd0, 8'h81);
    idle(140);
    // R6: divider 0 with duty 127 has one low tick per period
    wr(2'd1, 8'd127);
    wr(2'd0, 8'h80);
    idle(290);

    // R7: divider change with the count above the new range
    phase = "R7";
    wr(2'd1, 8'd6);
    while (m_cnt != 8'd100) run_cycle();
    wr(2'd0, 8'h83);
    idle(60);

    // R8: duty change mid-period
    phase = "R8";
    while (m_cnt != 8'd3) run_cycle();
    wr(2'd1, 8'd2);
    idle(40);

    // R9: stop, pin reverts to gpio_out
    phase = "R9";
    wr(2'd0, 8'h03);
    for (int i = 0; i < 10; i++) begin
      s_gpio = ~s_gpio;
      run_cycle();
    end
    s_gpio = 1'b1;
    idle(3);

    // R3: a fresh enable starts at count zero
    phase = "R3";
    wr(2'd1, 8'd8);
    wr(2'd0, 8'h83);
    idle(40);

    @(posedge clk);
    #2;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule